// File: doc/BRIEF.md
# MDIO Management Master with Programmable MDC

This block is the station-management side of an Ethernet MAC. It derives the management clock MDC from the system clock and serialises read and write frames to a PHY over the shared MDIO line. A 32-bit control word sets the divider and can suppress the all-ones lead-in. A command port starts one transaction at a time, and a single-cycle completion strobe reports it together with the 16 bits captured during a read.

MDC runs at sysclk/(4·N), where N is the 6-bit divider field. Each half period lasts 2·N system clocks. When N is zero MDC is parked low and no transaction can start. A new divider value is adopted only at the next MDC edge, so the half period in progress always completes with the count it started with. The half-period counter is brought out so that a test can observe it.

Top module: `mdio_master`

## Requirements
- R1: Once enabled with a stable divider N≠0, every MDC high phase and every MDC low phase lasts exactly 2·N system clocks.
- R2: With divider field 0, MDC is low from the cycle after the field is written, and it stays low.
- R3: A start request made while the divider field is 0 is ignored: busy stays low and no frame is sent.
- R4: With a stable divider, the MDC high and low durations are equal (50% duty).
- R5: A divider written partway through a half period does not shorten or stretch that half period. The new value sets the length of the half period that follows the next MDC edge.
- R6: The control word holds the divider in bits 6..1 and the preamble-disable flag in bit 7. It reads back those fields, and bits 31..8 and bit 0 read as 0. Reset clears the whole word.
- R7: With bit 7 clear, a frame begins with 32 driven 1 bits. With bit 7 set, the frame begins directly with the start pattern.
- R8: After the preamble, the frame carries 01, then the opcode (01 write, 10 read), then the 5-bit PHY address and the 5-bit register address, all MSB first. A write then drives 10 followed by the 16 data bits, MSB first.
- R9: In a read, MDIO is released (mdio_oe low) for the 2 turnaround bits and the 16 data bits. The data bits are sampled on MDC rising edges, and the first bit sampled becomes bit 15 of the result.
- R10: done pulses for exactly one cycle per frame, on the MDC rising edge that samples the last bit. cmd_rdata is valid in that cycle.
- R11: A start request made while busy is ignored: the running frame is unchanged and only one done pulse follows.
- R12: mdc_phase shows the half-period count: 0 at the start of each half period, rising by one per clock up to 2·N−1.
- R13: mdio_o changes only on the system-clock edge at which MDC falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read-back |
| mdc_phase | output | DIV_W+1 | Half-period counter for test observation |
| cmd_start | input | 1 | Request one management frame |
| cmd_read | input | 1 | 1 = read frame, 0 = write frame |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Data for a write frame |
| cmd_busy | output | 1 | Frame accepted and not yet finished |
| cmd_done | output | 1 | One-cycle completion strobe |
| cmd_rdata | output | 16 | Data captured by the last read |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO pad input |
| mdio_o | output | 1 | MDIO pad output value |
| mdio_oe | output | 1 | MDIO pad output enable |

## Verification
The hardest case to reach is a divider rewrite in the middle of a half period. The test waits until an MDC rising edge is seen at the port, lets three clocks pass, writes a smaller divider, and measures that the high phase still lasts the old 2·N while the following low phase uses the new count. A second hard case is a start request made while a frame is running. The test issues one with different fields a few clocks into a write frame and then checks the captured bit stream and the number of done pulses. A PHY model in the bench drives MDIO only when the block releases it, so the turnaround release and the read capture are checked against the data the model sent.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int BODY_W = 32;   // frame bits after the preamble
   localparam int TA_W   = 2;
   localparam int DAT_W  = 16;
   localparam int ADR_W  = 5;

   localparam logic [1:0] SOF_BITS = 2'b01;
   localparam logic [1:0] OPC_WR   = 2'b01;
   localparam logic [1:0] OPC_RD   = 2'b10;
   localparam logic [1:0] TA_DRIVE = 2'b10;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ARM,
      ST_SHIFT
   } shift_state_e;
endpackage

// File: rtl/mdc_gen.sv
module mdc_gen #(
   parameter int DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             mdc,
   output logic             rise_stb,
   output logic             fall_stb,
   output logic [DIV_W:0]   phase_cnt
);
   localparam int CW = DIV_W + 1;

   logic [DIV_W-1:0] act_q;
   logic [CW-1:0]    cnt_q;
   logic             mdc_q;
   logic [CW-1:0]    last_cnt;
   logic             turn;

   assign last_cnt = {act_q, 1'b0} - CW'(1);
   assign turn     = (div != '0) && (act_q != '0) && (cnt_q == last_cnt);
   assign rise_stb = turn && !mdc_q;
   assign fall_stb = turn && mdc_q;
   assign mdc       = mdc_q;
   assign phase_cnt = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= '0;
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (div == '0) begin
         act_q <= '0;
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (act_q == '0) begin
         act_q <= div;
         cnt_q <= '0;
      end else if (turn) begin
         mdc_q <= ~mdc_q;
         cnt_q <= '0;
         act_q <= div;
      end else begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   a_r2_parked_low: assert property (@(posedge clk) disable iff (!rst_n)
      (div == '0) |=> !mdc_q);
   a_r12_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q != '0) |-> (cnt_q < {act_q, 1'b0}));
   a_r5_count_held: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q != '0 && div != '0 && !turn) |=> $stable(act_q));
   a_r1_edge_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_stb || fall_stb) |=> (cnt_q == '0));
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
   import mdio_pkg::*;
#(
   parameter int PRE_LEN     = 32,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_ok,
   input  logic             no_pre,
   input  logic             rise_stb,
   input  logic             fall_stb,
   input  logic             start,
   input  logic             rd,
   input  logic [ADR_W-1:0] phy,
   input  logic [ADR_W-1:0] regad,
   input  logic [DAT_W-1:0] wdata,
   input  logic             mdio_i,
   output logic             busy,
   output logic             done,
   output logic [DAT_W-1:0] rdata,
   output logic             mdio_o,
   output logic             mdio_oe
);
   localparam int FRM_W = PRE_LEN + BODY_W;
   localparam int RW    = $clog2(FRM_W + 1);
   localparam logic [RW-1:0] N_FULL = RW'(FRM_W);
   localparam logic [RW-1:0] N_BODY = RW'(BODY_W);
   localparam logic [RW-1:0] N_DAT  = RW'(DAT_W);
   localparam logic [RW-1:0] N_REL  = RW'(TA_W + DAT_W);
   localparam logic [RW-1:0] N_ONE  = RW'(1);

   if (PRE_LEN < 1 || PRE_LEN > 64) begin : g_bad_pre
      $error("mdio_frame: PRE_LEN out of range");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("mdio_frame: SYNC_STAGES out of range");
   end

   // optional input synchroniser on the pad input
   logic mdio_s;
   if (SYNC_STAGES == 0) begin : g_nosync
      assign mdio_s = mdio_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[SYNC_STAGES-2+1-1:0], mdio_i} >> 0;
      end
      assign mdio_s = chain_q[SYNC_STAGES-1];
   end

   shift_state_e     state_q;
   logic [FRM_W-1:0] sr_q;
   logic [FRM_W-1:0] word;
   logic [RW-1:0]    remain_q;
   logic [RW-1:0]    nbits_q;
   logic [RW-1:0]    nxt_rem;
   logic             is_rd_q;
   logic             out_q;
   logic             oe_q;
   logic             done_q;
   logic [DAT_W-1:0] rd_sh_q;
   logic             accept;

   assign word = {{PRE_LEN{1'b1}}, SOF_BITS, (rd ? OPC_RD : OPC_WR), phy, regad,
                  (rd ? 2'b00 : TA_DRIVE), (rd ? {DAT_W{1'b0}} : wdata)};
   assign accept  = (state_q == ST_IDLE) && start && run_ok;
   assign nxt_rem = remain_q - N_ONE;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         sr_q     <= '0;
         remain_q <= '0;
         nbits_q  <= '0;
         is_rd_q  <= 1'b0;
         out_q    <= 1'b0;
         oe_q     <= 1'b0;
         done_q   <= 1'b0;
         rd_sh_q  <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  sr_q    <= no_pre ? (word << PRE_LEN) : word;
                  nbits_q <= no_pre ? N_BODY : N_FULL;
                  is_rd_q <= rd;
                  rd_sh_q <= '0;
                  state_q <= ST_ARM;
               end
            end
            ST_ARM: begin
               if (fall_stb) begin
                  out_q    <= sr_q[FRM_W-1];
                  sr_q     <= sr_q << 1;
                  remain_q <= nbits_q;
                  oe_q     <= 1'b1;
                  state_q  <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (rise_stb) begin
                  if (is_rd_q && remain_q <= N_DAT)
                     rd_sh_q <= {rd_sh_q[DAT_W-2:0], mdio_s};
                  if (remain_q == N_ONE) begin
                     done_q  <= 1'b1;
                     oe_q    <= 1'b0;
                     state_q <= ST_IDLE;
                  end
               end else if (fall_stb) begin
                  out_q    <= sr_q[FRM_W-1];
                  sr_q     <= sr_q << 1;
                  remain_q <= nxt_rem;
                  oe_q     <= !(is_rd_q && nxt_rem <= N_REL);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (state_q != ST_IDLE);
   assign done    = done_q;
   assign rdata   = rd_sh_q;
   assign mdio_o  = out_q;
   assign mdio_oe = oe_q;

   a_r3_no_start_parked: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !run_ok) |=> (state_q == ST_IDLE));
   a_r9_released: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SHIFT && is_rd_q && remain_q <= N_REL) |-> !oe_q);
   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   a_r11_busy_kind_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && start) |=> $stable(is_rd_q));
   a_r13_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(out_q) |-> $past(fall_stb));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int DIV_W       = 6,
   parameter int PRE_LEN     = 32,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [31:0]      cfg_wdata,
   output logic [31:0]      cfg_rdata,
   output logic [DIV_W:0]   mdc_phase,
   input  logic             cmd_start,
   input  logic             cmd_read,
   input  logic [4:0]       cmd_phy,
   input  logic [4:0]       cmd_reg,
   input  logic [15:0]      cmd_wdata,
   output logic             cmd_busy,
   output logic             cmd_done,
   output logic [15:0]      cmd_rdata,
   output logic             mdc,
   input  logic             mdio_i,
   output logic             mdio_o,
   output logic             mdio_oe
);
   localparam int DIS_BIT = 7;

   if (DIV_W < 1 || DIV_W > 6) begin : g_bad_div
      $error("mdio_master: DIV_W must lie in 1..6");
   end

   logic [DIV_W-1:0] div_q;
   logic             dis_q;
   logic             rise_stb;
   logic             fall_stb;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q <= '0;
         dis_q <= 1'b0;
      end else if (cfg_we) begin
         div_q <= cfg_wdata[DIV_W:1];
         dis_q <= cfg_wdata[DIS_BIT];
      end
   end

   always_comb begin
      cfg_rdata            = '0;
      cfg_rdata[DIS_BIT]   = dis_q;
      cfg_rdata[DIV_W:1]   = div_q;
   end

   mdc_gen #(.DIV_W(DIV_W)) u_clk (
      .clk       (clk),
      .rst_n     (rst_n),
      .div       (div_q),
      .mdc       (mdc),
      .rise_stb  (rise_stb),
      .fall_stb  (fall_stb),
      .phase_cnt (mdc_phase)
   );

   mdio_frame #(.PRE_LEN(PRE_LEN), .SYNC_STAGES(SYNC_STAGES)) u_frm (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_ok   (div_q != '0),
      .no_pre   (dis_q),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb),
      .start    (cmd_start),
      .rd       (cmd_read),
      .phy      (cmd_phy),
      .regad    (cmd_reg),
      .wdata    (cmd_wdata),
      .mdio_i   (mdio_i),
      .busy     (cmd_busy),
      .done     (cmd_done),
      .rdata    (cmd_rdata),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe)
   );

   a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata[31:8] == '0) && !cfg_rdata[0]);
   a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |-> !cmd_busy);
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [6:0]  mdc_phase;
   logic        cmd_start = 1'b0;
   logic        cmd_read = 1'b0;
   logic [4:0]  cmd_phy = '0;
   logic [4:0]  cmd_reg = '0;
   logic [15:0] cmd_wdata = '0;
   logic        cmd_busy, cmd_done;
   logic [15:0] cmd_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b0;

   always #2 clk = ~clk;

   mdio_master dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .mdc_phase(mdc_phase), .cmd_start(cmd_start),
      .cmd_read(cmd_read), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
      .cmd_wdata(cmd_wdata), .cmd_busy(cmd_busy), .cmd_done(cmd_done),
      .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o),
      .mdio_oe(mdio_oe)
   );

   int total = 0;
   int bad = 0;
   bit finished = 0;

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d @%0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference of the management clock (R1, R12)
   int r_div = 0, r_act = 0, r_cnt = 0, r_mdc = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         r_div = 0; r_act = 0; r_cnt = 0; r_mdc = 0;
      end else begin
         if (r_div == 0) begin
            r_mdc = 0; r_cnt = 0; r_act = 0;
         end else if (r_act == 0) begin
            r_act = r_div; r_cnt = 0;
         end else if (r_cnt == 2 * r_act - 1) begin
            r_mdc = 1 - r_mdc; r_cnt = 0; r_act = r_div;
         end else begin
            r_cnt++;
         end
         if (cfg_we) r_div = int'(cfg_wdata[6:1]);
      end
   end

   // per-cycle comparison, bus monitor and PHY model, all at the falling clock edge
   int mon_q[$];
   int p_mdc = 0, p_busy = 0, p_oe = 0, p_o = 0;
   bit seen_fall = 0;
   int rel_cnt = 0;
   int done_cnt = 0;
   int r13_viol = 0;
   logic [15:0] phy_word = 16'h0;

   always @(negedge clk) begin
      if (rst_n) begin
         check("R1", int'(mdc), r_mdc);
         check("R12", int'(mdc_phase), r_cnt);
         if (int'(mdio_o) != p_o && !(p_mdc == 1 && mdc == 1'b0)) r13_viol++;
         if (mdc && p_mdc == 0 && p_busy == 1 && seen_fall)
            mon_q.push_back(p_oe * 2 + p_o);
         if (!mdc && p_mdc == 1 && cmd_busy && mdio_oe) seen_fall = 1;
         if (mdio_oe || !cmd_busy) rel_cnt = 0;
         else if (!mdc && p_mdc == 1) begin
            mdio_i <= (rel_cnt < 2) ? 1'b0 : phy_word[15 - (rel_cnt - 2)];
            rel_cnt++;
         end
         if (cmd_done) done_cnt++;
         if (!cmd_busy) seen_fall = 0;
      end
      p_mdc = int'(mdc); p_busy = int'(cmd_busy);
      p_oe = int'(mdio_oe); p_o = int'(mdio_o);
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_cfg(logic [31:0] v);
      @(negedge clk);
      cfg_wdata = v; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pulse_start(bit rd, logic [4:0] ph, logic [4:0] rg, logic [15:0] wd);
      cmd_read = rd; cmd_phy = ph; cmd_reg = rg; cmd_wdata = wd; cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
   endtask

   task automatic wait_mdc(bit lvl);
      int guard = 0;
      while (mdc != lvl && guard < 2000) begin @(negedge clk); guard++; end
   endtask

   // run one frame and compare the observed bit stream (R7 R8 R9 R10 R11)
   task automatic run_frame(bit rd, bit nopre, logic [4:0] ph, logic [4:0] rg,
                            logic [15:0] wd, bit poke_busy);
      int exp_q[$];
      int mism = 0;
      int guard = 0;
      logic [31:0] body;
      body = {2'b01, (rd ? 2'b10 : 2'b01), ph, rg, (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : wd)};
      if (!nopre) for (int i = 0; i < 32; i++) exp_q.push_back(3);
      for (int i = 31; i >= 0; i--)
         exp_q.push_back((rd && i < 18) ? -1 : (2 + int'(body[i])));
      if (rd) phy_word = wd;
      mon_q.delete();
      done_cnt = 0;
      @(negedge clk);
      pulse_start(rd, ph, rg, wd);
      check("R11", int'(cmd_busy), 1);
      if (poke_busy) begin
         cyc(5);
         pulse_start(!rd, ~ph, ~rg, ~wd);
      end
      while (done_cnt == 0 && guard < 20000) begin @(negedge clk); guard++; end
      if (rd) check("R9", int'(cmd_rdata), int'(wd));
      cyc(30);
      check("R10", done_cnt, 1);
      check(nopre ? "R7" : "R8", mon_q.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < mon_q.size(); i++) begin
         if (exp_q[i] == -1) begin
            if (mon_q[i] / 2 != 0) mism++;
         end else if (mon_q[i] != exp_q[i]) mism++;
      end
      check(rd ? "R9" : "R8", mism, 0);
      if (poke_busy) check("R11", int'(cmd_busy), 0);
   endtask

   initial begin
      int hi, lo, cnt;
      cyc(4);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state (R6)
      check("R6", int'(cfg_rdata), 0);
      check("R2", int'(mdc), 0);
      check("R9", int'(mdio_oe), 0);
      check("R10", int'(cmd_busy), 0);

      // R6 layout and reserved bits
      write_cfg(32'hFFFF_FFFF);
      check("R6", int'(cfg_rdata), 32'hFE);
      write_cfg(32'h0000_0081);
      check("R6", int'(cfg_rdata), 32'h80);

      // R2 parked, R3 start ignored while divider is zero
      cyc(2);
      cnt = 0;
      for (int i = 0; i < 60; i++) begin @(negedge clk); if (mdc) cnt++; end
      check("R2", cnt, 0);
      pulse_start(1'b0, 5'h3, 5'h4, 16'h1234);
      cyc(2);
      check("R3", int'(cmd_busy), 0);
      check("R3", int'(mdio_oe), 0);

      // R1 and R4 with divider 3
      write_cfg(32'h0000_0006);
      wait_mdc(1'b0); wait_mdc(1'b1);
      hi = 0; while (mdc && hi < 1000) begin hi++; @(negedge clk); end
      lo = 0; while (!mdc && lo < 1000) begin lo++; @(negedge clk); end
      check("R1", hi, 6);
      check("R4", lo, hi);

      // R1 with divider 1
      write_cfg(32'h0000_0002);
      cyc(10);
      wait_mdc(1'b0); wait_mdc(1'b1);
      hi = 0; while (mdc && hi < 1000) begin hi++; @(negedge clk); end
      check("R1", hi, 2);

      // R5 divider change in the middle of a high phase
      write_cfg(32'h0000_000A);
      cyc(30);
      wait_mdc(1'b0); wait_mdc(1'b1);
      hi = 1;
      cyc(1); hi++;
      cyc(1); hi++;
      cfg_wdata = 32'h0000_0004; cfg_we = 1'b1;
      @(negedge clk); cfg_we = 1'b0; hi++;
      while (mdc && hi < 1000) begin @(negedge clk); if (mdc) hi++; end
      lo = 0; while (!mdc && lo < 1000) begin lo++; @(negedge clk); end
      check("R5", hi, 10);
      check("R5", lo, 4);

      // frames with divider 2
      write_cfg(32'h0000_0004);
      cyc(10);
      run_frame(1'b0, 1'b0, 5'h11, 5'h0A, 16'hBEEF, 1'b1);
      run_frame(1'b1, 1'b0, 5'h05, 5'h1F, 16'hA5C3, 1'b0);
      write_cfg(32'h0000_0084);
      cyc(10);
      run_frame(1'b0, 1'b1, 5'h1E, 5'h01, 16'h0F0F, 1'b0);
      run_frame(1'b1, 1'b1, 5'h00, 5'h12, 16'h8001, 1'b0);
      check("R13", r13_viol, 0);

      // R2 stop after frames
      write_cfg(32'h0000_0000);
      cyc(3);
      check("R2", int'(mdc), 0);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule